// File: doc/BRIEF.md
# Parity-Checked Eight-Way Instruction Tag Lookup

This block holds the tag array of an eight-way set-associative instruction cache and answers lookups against it. Every entry keeps a tag, an even-parity bit over that tag and two copies of the valid flag. A lookup reads all ways of the addressed set, compares them with the request and reports one of four outcomes: a hit with its way, a miss, or a detected error of a given kind. When an error is reported, the whole set is wiped, so the next access to it misses and refills. The error report carries an error address that combines the offending way and the set.

Addresses at the ports are line addresses: the physical address with the 5-bit offset of a 32-byte line (eight 32-bit instructions) already removed. The low SET_W bits select the set and the upper TAG_W bits form the tag. A refill port installs a fresh tag into a way picked by a rotating victim counter. A flush port drops one line without any error checking. A diagnostic write port stores a chosen tag and can deliberately corrupt its parity or its valid copies, so that software or a test can plant faults.

Top module: `ictag_lookup`

## Requirements
- R1: A lookup presented with `lk_valid` at clock edge N produces a one-cycle `rsp_valid` strobe registered at edge N+2. While `rsp_valid` is low, `rsp_hit`, `rsp_way`, `rsp_err` and `rsp_err_addr` are zero.
- R2: When no error is reported and exactly one live way holds the requested tag, the response has `rsp_hit`=1, `rsp_way` set to that way and `rsp_err`=0.
- R3: When no live way holds the tag, or several do while multi-hit reporting is disabled, the response is a miss: `rsp_hit`=0 and `rsp_err`=0.
- R4: A way is live when either valid copy is set. A way whose copies differ is a valid-copy error, reported as `rsp_err`=1 only while `en_vld_err` is high.
- R5: A live way whose stored parity bit differs from the XOR of its tag bits is a parity error, reported as `rsp_err`=2 only while `en_par_err` is high.
- R6: More than one live way holding the requested tag is a multi-hit, reported as `rsp_err`=3 only while `en_mhit_err` is high.
- R7: Error kinds are ranked valid-copy over parity over multi-hit. A kind whose enable is low is skipped and the next kind is examined.
- R8: With an error reported, `rsp_err_addr` equals (way << 6) | set, where the way is the lowest-numbered way showing the reported kind. With `rsp_err`=0 it is zero.
- R9: On a reported error, every way of the looked-up set is cleared in the same edge that registers the response, so a later lookup to that set misses.
- R10: A refill writes the way given by a counter that starts at 0 after reset and advances by one (modulo 8) per refill. The new entry has both valid copies set and correct parity.
- R11: A diagnostic write stores the given tag, parity = XOR(tag) XOR `dw_par_inj`, valid copy 1 = `dw_valid1` and valid copy 0 = `dw_valid1` XOR `dw_vld_inj`.
- R12: A flush clears both valid copies of the lowest-numbered live way in its set holding the flush tag. It reports nothing and leaves all other ways, including faulty ones, untouched.
- R13: After reset every entry is empty, no response is pending and the victim counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | TAG_W+SET_W | Lookup line address {tag, set} |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Response is a hit |
| rsp_way | output | 3 | Hit way |
| rsp_err | output | 2 | 0 none, 1 valid-copy, 2 parity, 3 multi-hit |
| rsp_err_addr | output | 9 | (way << 6) \| set of the reported error |
| fill_valid | input | 1 | Refill request strobe |
| fill_addr | input | TAG_W+SET_W | Refill line address |
| flush_valid | input | 1 | Flush request strobe |
| flush_addr | input | TAG_W+SET_W | Flush line address |
| dw_valid | input | 1 | Diagnostic write strobe |
| dw_set | input | SET_W | Diagnostic write set |
| dw_way | input | 3 | Diagnostic write way |
| dw_tag | input | TAG_W | Diagnostic write tag |
| dw_valid1 | input | 1 | Value of valid copy 1 |
| dw_par_inj | input | 1 | Invert the stored parity |
| dw_vld_inj | input | 1 | Make valid copy 0 differ from copy 1 |
| en_vld_err | input | 1 | Enable valid-copy error reporting |
| en_par_err | input | 1 | Enable parity error reporting |
| en_mhit_err | input | 1 | Enable multi-hit reporting |

## Verification
The hardest situation to reach from the ports is a set holding two faults of different kinds at once, because refills always write clean entries and any reported error wipes the set. The bench uses diagnostic writes to plant a valid-copy fault and a parity fault side by side. It first looks up with valid-copy reporting disabled to see the parity fault. It then replants both faults and looks up with all enables high to see the ranking. Multi-hit is reached the same way, by writing one tag into two ways, and the lack of set clearing on a flush is shown by a faulty neighbour way that still hits afterwards.

// File: rtl/ictag_pkg.sv
package ictag_pkg;
    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_VALID  = 2'd1,
        ERR_PARITY = 2'd2,
        ERR_MULTI  = 2'd3
    } err_kind_e;
endpackage

// File: rtl/ictag_way_check.sv
// Per-way status: valid-copy mismatch, parity fault, tag match.
module ictag_way_check #(
    parameter int TAG_W = 12,
    localparam int ENT_W = TAG_W + 3
) (
    input  logic [ENT_W-1:0] ent,
    input  logic [TAG_W-1:0] req_tag,
    output logic             vmis,
    output logic             perr,
    output logic             match
);
    logic             live;
    logic [TAG_W-1:0] stored_tag;

    always_comb begin
        stored_tag = ent[ENT_W-1:3];
        live       = ent[1] | ent[0];
        vmis       = ent[1] ^ ent[0];
        perr       = live && ((^stored_tag) != ent[2]);
        match      = live && (stored_tag == req_tag);
    end
endmodule

// File: rtl/ictag_classify.sv
// Ranks error kinds (R7) and resolves the hit way.
module ictag_classify
    import ictag_pkg::*;
#(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  vmis,
    input  logic [WAYS-1:0]  perr,
    input  logic [WAYS-1:0]  match,
    input  logic             en_vld,
    input  logic             en_par,
    input  logic             en_mhit,
    output err_kind_e        kind,
    output logic [WAY_W-1:0] err_way,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way
);
    logic [WAY_W-1:0] vm_way, pe_way, mt_way;
    logic             multi, single;

    always_comb begin
        vm_way = '0;
        pe_way = '0;
        mt_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vmis[w])  vm_way = WAY_W'(w);
            if (perr[w])  pe_way = WAY_W'(w);
            if (match[w]) mt_way = WAY_W'(w);
        end
        multi  = $countones(match) > 1;
        single = $countones(match) == 1;

        if (en_vld && |vmis) begin
            kind    = ERR_VALID;
            err_way = vm_way;
        end else if (en_par && |perr) begin
            kind    = ERR_PARITY;
            err_way = pe_way;
        end else if (en_mhit && multi) begin
            kind    = ERR_MULTI;
            err_way = mt_way;
        end else begin
            kind    = ERR_NONE;
            err_way = '0;
        end
        hit     = (kind == ERR_NONE) && single;
        hit_way = mt_way;
    end
endmodule

// File: rtl/ictag_victim.sv
// Rotating refill way pointer (R10).
module ictag_victim #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [WAY_W-1:0] way
);
    logic [WAY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv) cnt_d = (cnt_q == WAY_W'(WAYS - 1)) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign way = cnt_q;
endmodule

// File: rtl/ictag_lookup.sv
module ictag_lookup
    import ictag_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int SET_W = 4,
    parameter int TAG_W = 12,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int LA_W    = TAG_W + SET_W,
    localparam int SETS    = 1 << SET_W,
    localparam int ENT_W   = TAG_W + 3,
    localparam int EADDR_W = WAY_W + 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [LA_W-1:0]    lk_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [WAY_W-1:0]   rsp_way,
    output logic [1:0]         rsp_err,
    output logic [EADDR_W-1:0] rsp_err_addr,
    input  logic               fill_valid,
    input  logic [LA_W-1:0]    fill_addr,
    input  logic               flush_valid,
    input  logic [LA_W-1:0]    flush_addr,
    input  logic               dw_valid,
    input  logic [SET_W-1:0]   dw_set,
    input  logic [WAY_W-1:0]   dw_way,
    input  logic [TAG_W-1:0]   dw_tag,
    input  logic               dw_valid1,
    input  logic               dw_par_inj,
    input  logic               dw_vld_inj,
    input  logic               en_vld_err,
    input  logic               en_par_err,
    input  logic               en_mhit_err
);
    // Entry layout: {tag, parity, valid copy 1, valid copy 0}
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][ENT_W-1:0] arr;
        logic                                 s1_vld;
        logic [TAG_W-1:0]                     s1_tag;
        logic [SET_W-1:0]                     s1_set;
        logic [WAYS-1:0][ENT_W-1:0]           s1_ent;
        logic                                 rsp_vld;
        logic                                 rsp_hit;
        logic [WAY_W-1:0]                     rsp_way;
        logic [1:0]                           rsp_err;
        logic [EADDR_W-1:0]                   rsp_eaddr;
    } state_t;

    state_t st_d, st_q;

    logic [TAG_W-1:0] lk_tag, fill_tag, flush_tag;
    logic [SET_W-1:0] lk_set, fill_set, flush_set;

    assign lk_tag    = lk_addr[LA_W-1 -: TAG_W];
    assign lk_set    = lk_addr[SET_W-1:0];
    assign fill_tag  = fill_addr[LA_W-1 -: TAG_W];
    assign fill_set  = fill_addr[SET_W-1:0];
    assign flush_tag = flush_addr[LA_W-1 -: TAG_W];
    assign flush_set = flush_addr[SET_W-1:0];

    // Stage-two per-way status
    logic [WAYS-1:0] w_vmis, w_perr, w_match;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        ictag_way_check #(.TAG_W(TAG_W)) i_way_check (
            .ent     (st_q.s1_ent[g]),
            .req_tag (st_q.s1_tag),
            .vmis    (w_vmis[g]),
            .perr    (w_perr[g]),
            .match   (w_match[g])
        );
    end

    err_kind_e        cls_kind;
    logic [WAY_W-1:0] cls_err_way, cls_hit_way;
    logic             cls_hit;

    ictag_classify #(.WAYS(WAYS)) i_classify (
        .vmis    (w_vmis),
        .perr    (w_perr),
        .match   (w_match),
        .en_vld  (en_vld_err),
        .en_par  (en_par_err),
        .en_mhit (en_mhit_err),
        .kind    (cls_kind),
        .err_way (cls_err_way),
        .hit     (cls_hit),
        .hit_way (cls_hit_way)
    );

    logic [WAY_W-1:0] victim_way;

    ictag_victim #(.WAYS(WAYS)) i_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fill_valid),
        .way   (victim_way)
    );

    // Flush probe: lowest live way holding the flush tag
    logic             fl_hit;
    logic [WAY_W-1:0] fl_way;
    logic [ENT_W-1:0] fl_ent;

    always_comb begin
        fl_hit = 1'b0;
        fl_way = '0;
        fl_ent = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            fl_ent = st_q.arr[flush_set][w];
            if ((fl_ent[1] | fl_ent[0]) && fl_ent[ENT_W-1:3] == flush_tag) begin
                fl_hit = 1'b1;
                fl_way = WAY_W'(w);
            end
        end
    end

    logic err_now;
    assign err_now = st_q.s1_vld && (cls_kind != ERR_NONE);

    always_comb begin
        st_d = st_q;

        // Stage one: read the addressed set
        st_d.s1_vld = lk_valid;
        st_d.s1_tag = lk_tag;
        st_d.s1_set = lk_set;
        st_d.s1_ent = st_q.arr[lk_set];

        // Stage two: register the classified response
        st_d.rsp_vld   = st_q.s1_vld;
        st_d.rsp_hit   = st_q.s1_vld && cls_hit;
        st_d.rsp_way   = (st_q.s1_vld && cls_hit) ? cls_hit_way : '0;
        st_d.rsp_err   = st_q.s1_vld ? 2'(cls_kind) : 2'd0;
        st_d.rsp_eaddr = err_now
                       ? ((EADDR_W'(cls_err_way) << 6) | EADDR_W'(st_q.s1_set))
                       : '0;

        // Array writes, later ones take precedence
        if (fill_valid)
            st_d.arr[fill_set][victim_way] = {fill_tag, ^fill_tag, 1'b1, 1'b1};
        if (dw_valid)
            st_d.arr[dw_set][dw_way] = {dw_tag, (^dw_tag) ^ dw_par_inj,
                                        dw_valid1, dw_valid1 ^ dw_vld_inj};
        if (flush_valid && fl_hit)
            st_d.arr[flush_set][fl_way][1:0] = 2'b00;
        if (err_now)
            st_d.arr[st_q.s1_set] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.rsp_vld;
    assign rsp_hit      = st_q.rsp_hit;
    assign rsp_way      = st_q.rsp_way;
    assign rsp_err      = st_q.rsp_err;
    assign rsp_err_addr = st_q.rsp_eaddr;
endmodule

// File: rtl/ictag_lookup_chk.sv
module ictag_lookup_chk #(
    parameter int SET_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [SET_W-1:0] lk_set,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [1:0]       rsp_err,
    input logic [5:0]       eaddr_set
);
    // R1
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ##2 rsp_valid);

    // R1
    rsp_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_err == 2'd0));

    // R2
    hit_without_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> rsp_err == 2'd0);

    // R8
    err_addr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err != 2'd0) |-> eaddr_set == 6'($past(lk_set, 2)));
endmodule

bind ictag_lookup ictag_lookup_chk #(.SET_W(SET_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_set    (lk_addr[SET_W-1:0]),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_err   (rsp_err),
    .eaddr_set (rsp_err_addr[5:0])
);

// File: tb/test_ictag_lookup.sv
`timescale 1ns/1ps
module test_ictag_lookup;
    localparam int SET_W = 4;
    localparam int TAG_W = 12;
    localparam int LA_W  = TAG_W + SET_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 0, fill_valid = 0, flush_valid = 0, dw_valid = 0;
    logic [LA_W-1:0] lk_addr = '0, fill_addr = '0, flush_addr = '0;
    logic [SET_W-1:0] dw_set = '0;
    logic [2:0] dw_way = '0;
    logic [TAG_W-1:0] dw_tag = '0;
    logic dw_valid1 = 0, dw_par_inj = 0, dw_vld_inj = 0;
    logic en_vld_err = 1, en_par_err = 1, en_mhit_err = 1;
    logic rsp_valid, rsp_hit;
    logic [2:0] rsp_way;
    logic [1:0] rsp_err;
    logic [8:0] rsp_err_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ictag_lookup i_ictag_lookup (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_err(rsp_err), .rsp_err_addr(rsp_err_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .flush_valid(flush_valid), .flush_addr(flush_addr),
        .dw_valid(dw_valid), .dw_set(dw_set), .dw_way(dw_way), .dw_tag(dw_tag),
        .dw_valid1(dw_valid1), .dw_par_inj(dw_par_inj), .dw_vld_inj(dw_vld_inj),
        .en_vld_err(en_vld_err), .en_par_err(en_par_err), .en_mhit_err(en_mhit_err)
    );

    function automatic logic [LA_W-1:0] la(input logic [TAG_W-1:0] t, input logic [SET_W-1:0] s);
        return {t, s};
    endfunction

    task automatic expect_rsp(input string req, input logic e_hit, input logic [2:0] e_way,
                              input logic [1:0] e_err, input logic [8:0] e_ea);
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_hit !== e_hit || rsp_err !== e_err
            || (e_hit && rsp_way !== e_way) || rsp_err_addr !== e_ea) begin
            n_bad++;
            $display("FAIL %s: got v=%0b hit=%0b way=%0d err=%0d ea=0x%0h exp v=1 hit=%0b way=%0d err=%0d ea=0x%0h",
                     req, rsp_valid, rsp_hit, rsp_way, rsp_err, rsp_err_addr,
                     e_hit, e_way, e_err, e_ea);
        end
    endtask

    // Lookup: issue, wait two edges, sample between edges
    task automatic lookup(input logic [TAG_W-1:0] t, input logic [SET_W-1:0] s);
        lk_valid = 1'b1; lk_addr = la(t, s);
        @(negedge clk); lk_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill(input logic [TAG_W-1:0] t, input logic [SET_W-1:0] s);
        fill_valid = 1'b1; fill_addr = la(t, s);
        @(negedge clk); fill_valid = 1'b0;
    endtask

    task automatic flush(input logic [TAG_W-1:0] t, input logic [SET_W-1:0] s);
        flush_valid = 1'b1; flush_addr = la(t, s);
        @(negedge clk); flush_valid = 1'b0;
    endtask

    task automatic dwrite(input logic [SET_W-1:0] s, input logic [2:0] w, input logic [TAG_W-1:0] t,
                          input logic v1, input logic pinj, input logic vinj);
        dw_valid = 1'b1; dw_set = s; dw_way = w; dw_tag = t;
        dw_valid1 = v1; dw_par_inj = pinj; dw_vld_inj = vinj;
        @(negedge clk); dw_valid = 1'b0;
    endtask

    task automatic t_reset();
        n_chk++;
        if (rsp_valid !== 1'b0 || rsp_err !== 2'd0) begin
            n_bad++;
            $display("FAIL R13: rsp_valid=%0b err=%0d exp 0 0", rsp_valid, rsp_err);
        end
        lookup(12'h123, 4'd3);
        expect_rsp("R13 empty after reset", 0, 0, 0, 0);
    endtask

    task automatic t_fill_hit();
        fill(12'h123, 4'd3);                       // victim 0
        lookup(12'h123, 4'd3);
        expect_rsp("R2 hit after fill, R10 clean entry", 1, 0, 0, 0);
        lookup(12'h124, 4'd3);
        expect_rsp("R3 miss other tag", 0, 0, 0, 0);
    endtask

    task automatic t_victim_rotation();
        for (int k = 0; k < 8; k++) fill(12'h200 + 12'(k), 4'd5); // ways 1..7,0
        lookup(12'h200, 4'd5);
        expect_rsp("R10 first rotation way", 1, 1, 0, 0);
        lookup(12'h203, 4'd5);
        expect_rsp("R10 middle rotation way", 1, 4, 0, 0);
        lookup(12'h207, 4'd5);
        expect_rsp("R10 wrap to way 0", 1, 0, 0, 0);
    endtask

    task automatic t_parity();
        dwrite(4'd7, 3'd2, 12'h0A5, 1, 1, 0);
        en_par_err = 1'b0;
        lookup(12'h0A5, 4'd7);
        expect_rsp("R5 parity disabled gives hit", 1, 2, 0, 0);
        en_par_err = 1'b1;
        lookup(12'h0A5, 4'd7);
        expect_rsp("R5 R11 parity error", 0, 0, 2, 9'h087);
        lookup(12'h0A5, 4'd7);
        expect_rsp("R9 set cleared after error", 0, 0, 0, 0);
    endtask

    task automatic t_priority();
        dwrite(4'd8, 3'd1, 12'h111, 1, 1, 0);
        dwrite(4'd8, 3'd4, 12'h444, 1, 0, 1);
        en_vld_err = 1'b0;
        lookup(12'h444, 4'd8);
        expect_rsp("R7 valid disabled falls to parity", 0, 0, 2, 9'h048);
        en_vld_err = 1'b1;
        dwrite(4'd8, 3'd1, 12'h111, 1, 1, 0);
        dwrite(4'd8, 3'd4, 12'h444, 1, 0, 1);
        lookup(12'h444, 4'd8);
        expect_rsp("R4 R7 valid-copy error ranks first", 0, 0, 1, 9'h108);
        lookup(12'h111, 4'd8);
        expect_rsp("R9 priority set cleared", 0, 0, 0, 0);
        dwrite(4'd12, 3'd6, 12'h321, 0, 0, 1);
        lookup(12'h999, 4'd12);
        expect_rsp("R11 R4 copy0 set by inject", 0, 0, 1, 9'h18C);
    endtask

    task automatic t_multihit();
        dwrite(4'd9, 3'd3, 12'h777, 1, 0, 0);
        dwrite(4'd9, 3'd6, 12'h777, 1, 0, 0);
        en_mhit_err = 1'b0;
        lookup(12'h777, 4'd9);
        expect_rsp("R3 R6 multi-hit disabled is miss", 0, 0, 0, 0);
        en_mhit_err = 1'b1;
        lookup(12'h777, 4'd9);
        expect_rsp("R6 R8 multi-hit error", 0, 0, 3, 9'h0C9);
    endtask

    task automatic t_flush();
        fill(12'hF0F, 4'd10);                      // counter at 1
        lookup(12'hF0F, 4'd10);
        expect_rsp("R10 counter continues", 1, 1, 0, 0);
        flush(12'hF0F, 4'd10);
        lookup(12'hF0F, 4'd10);
        expect_rsp("R12 flushed line misses", 0, 0, 0, 0);
        dwrite(4'd11, 3'd0, 12'h0C0, 1, 1, 0);
        dwrite(4'd11, 3'd5, 12'h0D0, 1, 0, 0);
        flush(12'h0D0, 4'd11);
        en_par_err = 1'b0;
        lookup(12'h0D0, 4'd11);
        expect_rsp("R12 flushed way gone", 0, 0, 0, 0);
        lookup(12'h0C0, 4'd11);
        expect_rsp("R12 faulty neighbour untouched", 1, 0, 0, 0);
        en_par_err = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_victim_rotation();
        t_parity();
        t_priority();
        t_multihit();
        t_flush();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule